// File: doc/BRIEF.md
# In-Place Two-Bank Radix-2 FFT Engine

This block computes a fixed-point complex discrete Fourier transform of N points (16 by default) using one radix-2 butterfly. The points sit in two single-write memory banks, and a point's bank is the parity of its address bits. Because the two points of a butterfly differ in exactly one address bit, they always sit in different banks. Both banks therefore deliver the butterfly's operands in the same cycle. The butterfly result is registered and written back one cycle later, over the same two locations.

A host fills the banks through a simple word port while the engine is idle, with point n at address n. The host then pulses start and waits for done. It reads bin k from the bit-reversed address of k. Each of the log2(N) stages runs N/2 butterflies followed by one bubble cycle, which lets the last write of a stage land before the next stage reads. Each stage halves its results with rounding, so the output is the transform divided by N.

Top module: `fft_dualbank`

## Requirements
- R1: After reset, busy_o and done_o are both 0.
- R2: A start_i pulse sampled while busy_o is 0 sets busy_o on the next clock edge and clears done_o at that same edge.
- R3: busy_o stays high for exactly log2(N)*(N/2+1) cycles (36 for N=16). done_o rises at the edge where busy_o falls and stays high until the next accepted start. busy_o and done_o are never both high.
- R4: After done_o rises, the host location whose address is the log2(N)-bit reversal of k holds X[k]/N, with X[k] = sum over n of x[n]*exp(-j*2*pi*n*k/N) and x[n] the value loaded at address n. Each component matches the rounded ideal within 3 LSB, for two's-complement inputs of magnitude up to 8000.
- R5: While idle, a host write (host_we_i high at a clock edge) stores the real and imaginary words at host_addr_i. The read port returns the word at host_addr_i combinationally.
- R6: Host writes made while busy_o is high have no effect on the stored data or on the result.
- R7: While busy_o is high, both host read data outputs are 0.
- R8: A start_i pulse while busy_o is high is ignored: the running transform neither restarts nor changes length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | Transform finished, held until next start |
| host_we_i | input | 1 | Host write enable, idle only |
| host_addr_i | input | log2(N) | Host point address |
| host_wdata_re_i | input | 16 | Host write data, real part |
| host_wdata_im_i | input | 16 | Host write data, imaginary part |
| host_rdata_re_o | output | 16 | Host read data, real part |
| host_rdata_im_o | output | 16 | Host read data, imaginary part |

## Verification
A wrong stage, butterfly or twiddle index, or a wrong bank parity, stays hidden until the host unloads the banks after done. It then shows up as many output bins that are wrong at once, well beyond the 3 LSB tolerance, so an impulse, a single tone and random frames each expose it. Errors in the control sequence show up at the ports sooner. A missing bubble or an off-by-one counter changes the busy length counted from the start edge, and a leak of host access during busy either corrupts the result or makes the read data non-zero within that same run.

// File: rtl/fft_pkg.sv
package fft_pkg;
  localparam int DATA_W = 16;
  localparam int TW_W   = 16;  // twiddle Q1.(TW_W-2)

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [TW_W-1:0] re;
    logic signed [TW_W-1:0] im;
  } twid_t;
endpackage

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter int N = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   rd_valid_o,
  output logic                   finish_o,
  output logic [$clog2(N)-1:0]   addr_a_o,
  output logic [$clog2(N)-1:0]   addr_b_o,
  output logic [$clog2(N)-2:0]   tw_idx_o
);
  localparam int AW   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int SW   = $clog2(AW) + 1;

  logic          busy_q;
  logic [SW-1:0] stage_q;
  logic [AW-1:0] bf_q;     // 0..HALF, HALF is the bubble slot
  logic          bubble;
  logic          last_stage;

  assign bubble     = (bf_q == AW'(HALF));
  assign last_stage = (stage_q == SW'(AW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stage_q <= '0;
      bf_q    <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        stage_q <= '0;
        bf_q    <= '0;
      end
    end else if (bubble) begin
      bf_q <= '0;
      if (last_stage) busy_q  <= 1'b0;
      else            stage_q <= stage_q + 1'b1;
    end else begin
      bf_q <= bf_q + 1'b1;
    end
  end

  // insert a zero at bit position p = AW-1-stage; group index is j >> p
  always_comb begin
    logic [AW-2:0] j;
    logic [AW-2:0] grp;
    int            p;
    j   = bf_q[AW-2:0];
    p   = AW - 1 - int'(stage_q);
    grp = j >> p;
    addr_a_o = '0;
    for (int i = 0; i < AW; i++) begin
      if (i < p)      addr_a_o[i] = j[i];
      else if (i > p) addr_a_o[i] = j[i-1];
    end
    addr_b_o = addr_a_o | (AW'(1) << p);
    for (int i = 0; i < AW - 1; i++) tw_idx_o[i] = grp[AW-2-i];
  end

  assign busy_o     = busy_q;
  assign rd_valid_o = busy_q && !bubble;
  assign finish_o   = busy_q && bubble && last_stage;
endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
  import fft_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [$clog2(N)-2:0] idx_i,
  output twid_t                w_o
);
  localparam int  HALF  = N / 2;
  localparam real SCALE = real'(1 << (TW_W - 2));
  localparam real TWO_PI = 6.283185307179586;

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  twid_t tab [HALF];

  // w[k] = exp(-j*2*pi*k/N)
  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam real ANG = TWO_PI * real'(k) / real'(N);
    localparam int  CRE = rnd($cos(ANG) * SCALE);
    localparam int  CIM = rnd(-$sin(ANG) * SCALE);
    assign tab[k].re = TW_W'(CRE);
    assign tab[k].im = TW_W'(CIM);
  end

  assign w_o = tab[idx_i];
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
  import fft_pkg::*;
(
  input  cplx_t a_i,
  input  cplx_t b_i,
  input  twid_t w_i,
  output cplx_t a_o,
  output cplx_t b_o
);
  localparam int PW  = DATA_W + TW_W + 1;
  localparam int FRC = TW_W - 2;

  function automatic logic signed [DATA_W-1:0] scale_rnd(input logic signed [PW:0] s);
    logic signed [PW:0] t;
    t = (s + (PW+1)'(1 <<< FRC)) >>> (FRC + 1);  // twiddle fraction plus stage halving
    return t[DATA_W-1:0];
  endfunction

  logic signed [PW-1:0] pr, pi;
  logic signed [PW:0]   ar, ai;

  assign pr = PW'(b_i.re * w_i.re) - PW'(b_i.im * w_i.im);
  assign pi = PW'(b_i.re * w_i.im) + PW'(b_i.im * w_i.re);
  assign ar = (PW+1)'(a_i.re) <<< FRC;
  assign ai = (PW+1)'(a_i.im) <<< FRC;

  assign a_o.re = scale_rnd(ar + (PW+1)'(pr));
  assign a_o.im = scale_rnd(ai + (PW+1)'(pi));
  assign b_o.re = scale_rnd(ar - (PW+1)'(pr));
  assign b_o.im = scale_rnd(ai - (PW+1)'(pi));
endmodule

// File: rtl/fft_bank.sv
module fft_bank
  import fft_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] wr_row_i,
  input  cplx_t                    wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_row_i,
  output cplx_t                    rd_data_o
);
  cplx_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_row_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_row_i];
endmodule

// File: rtl/fft_dualbank.sv
module fft_dualbank
  import fft_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  input  logic                     host_we_i,
  input  logic [$clog2(N)-1:0]     host_addr_i,
  input  logic signed [DATA_W-1:0] host_wdata_re_i,
  input  logic signed [DATA_W-1:0] host_wdata_im_i,
  output logic signed [DATA_W-1:0] host_rdata_re_o,
  output logic signed [DATA_W-1:0] host_rdata_im_o
);
  localparam int AW   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int RW   = AW - 1;

  logic          busy, rd_valid, finish;
  logic [AW-1:0] addr_a, addr_b;
  logic [AW-2:0] tw_idx;
  twid_t         w;
  cplx_t         op_a, op_b, res_a, res_b;
  logic          a_bank;

  fft_addr_gen #(.N(N)) u_agen (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .rd_valid_o(rd_valid), .finish_o(finish),
    .addr_a_o(addr_a), .addr_b_o(addr_b), .tw_idx_o(tw_idx)
  );

  fft_twiddle_rom #(.N(N)) u_rom (.idx_i(tw_idx), .w_o(w));

  assign a_bank = ^addr_a;  // addr_b lands in the other bank

  // write-back stage
  logic          wr_valid_q;
  logic [AW-1:0] wr_addr_a_q, wr_addr_b_q;
  cplx_t         wr_a_q, wr_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q  <= 1'b0;
      wr_addr_a_q <= '0;
      wr_addr_b_q <= '0;
      wr_a_q      <= '0;
      wr_b_q      <= '0;
    end else begin
      wr_valid_q <= rd_valid;
      if (rd_valid) begin
        wr_addr_a_q <= addr_a;
        wr_addr_b_q <= addr_b;
        wr_a_q      <= res_a;
        wr_b_q      <= res_b;
      end
    end
  end

  cplx_t rd_data [2];
  logic  host_bank;
  assign host_bank = ^host_addr_i;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          we;
    logic [RW-1:0] wr_row, rd_row;
    cplx_t         wr_data;
    logic          eng_is_a, rd_is_a;

    assign eng_is_a = ((^wr_addr_a_q) == 1'(b));
    assign rd_is_a  = (a_bank == 1'(b));

    always_comb begin
      if (busy) begin
        we      = wr_valid_q;
        wr_row  = eng_is_a ? wr_addr_a_q[AW-1:1] : wr_addr_b_q[AW-1:1];
        wr_data = eng_is_a ? wr_a_q : wr_b_q;
        rd_row  = rd_is_a ? addr_a[AW-1:1] : addr_b[AW-1:1];
      end else begin
        we      = host_we_i && (host_bank == 1'(b));
        wr_row  = host_addr_i[AW-1:1];
        wr_data = '{re: host_wdata_re_i, im: host_wdata_im_i};
        rd_row  = host_addr_i[AW-1:1];
      end
    end

    fft_bank #(.DEPTH(HALF)) u_bank (
      .clk_i, .we_i(we), .wr_row_i(wr_row), .wr_data_i(wr_data),
      .rd_row_i(rd_row), .rd_data_o(rd_data[b])
    );
  end

  assign op_a = a_bank ? rd_data[1] : rd_data[0];
  assign op_b = a_bank ? rd_data[0] : rd_data[1];

  fft_butterfly u_bfly (.a_i(op_a), .b_i(op_b), .w_i(w), .a_o(res_a), .b_o(res_b));

  logic done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q <= 1'b0;
    else if (finish)            done_q <= 1'b1;
    else if (start_i && !busy)  done_q <= 1'b0;
  end

  cplx_t host_rd;
  assign host_rd         = host_bank ? rd_data[1] : rd_data[0];
  assign host_rdata_re_o = busy ? '0 : host_rd.re;
  assign host_rdata_im_o = busy ? '0 : host_rd.im;
  assign busy_o          = busy;
  assign done_o          = done_q;
endmodule

// File: rtl/fft_dualbank_chk.sv
module fft_dualbank_chk
  import fft_pkg::*;
#(
  parameter int N = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     host_we_i,
  input logic [$clog2(N)-1:0]     host_addr_i,
  input logic signed [DATA_W-1:0] host_wdata_re_i,
  input logic signed [DATA_W-1:0] host_wdata_im_i,
  input logic signed [DATA_W-1:0] host_rdata_re_o,
  input logic signed [DATA_W-1:0] host_rdata_im_o
);
  localparam int AW    = $clog2(N);
  localparam int TOTAL = AW * (N / 2 + 1);

  int unsigned run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);

  a_r3_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == TOTAL);

  a_r3_done_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $rose(done_o));

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r3_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r7_rdata_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> host_rdata_re_o == '0 && host_rdata_im_o == '0);

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_cnt < TOTAL - 1 |=> busy_o);
endmodule

bind fft_dualbank fft_dualbank_chk #(.N(N)) chk_i (.*);

// File: tb/fft_dualbank_tb_top.sv
`timescale 1ns/1ps
module fft_dualbank_tb_top;
  import fft_pkg::*;

  localparam int N     = 16;
  localparam int AW    = $clog2(N);
  localparam int TOTAL = AW * (N / 2 + 1);
  localparam int TOL   = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic signed [DATA_W-1:0] host_wdata_re_i = '0, host_wdata_im_i = '0;
  logic signed [DATA_W-1:0] host_rdata_re_o, host_rdata_im_o;
  logic busy_o, done_o;

  always #5 clk_i = ~clk_i;

  fft_dualbank #(.N(N)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  int xr [N], xi [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int bitrev(input int v);
    int r = 0;
    for (int i = 0; i < AW; i++) if (v[i]) r |= 1 << (AW - 1 - i);
    return r;
  endfunction

  function automatic int rndr(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic host_write(input int a, input int re, input int im);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = AW'(a);
    host_wdata_re_i = DATA_W'(re); host_wdata_im_i = DATA_W'(im);
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic host_read(input int a, output int re, output int im);
    @(negedge clk_i);
    host_addr_i = AW'(a);
    #1;
    re = int'(host_rdata_re_o); im = int'(host_rdata_im_o);
  endtask

  task automatic load_frame();
    for (int n = 0; n < N; n++) host_write(n, xr[n], xi[n]);
    for (int n = 0; n < N; n += 5) begin
      int re, im;
      host_read(n, re, im);
      chk(re == xr[n] && im == xi[n], "R5 readback", re, xr[n]);
    end
  endtask

  // disturb: host write, read and start pulse while running
  task automatic run_and_check(input bit disturb);
    int busy_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(done_o == 1'b0, "R2 done cleared", done_o, 0);
    while (busy_o && busy_cnt < 1000) begin
      busy_cnt++;
      if (disturb && busy_cnt == 5) begin
        host_we_i = 1'b1; host_addr_i = '0;
        host_wdata_re_i = 16'sd12345; host_wdata_im_i = -16'sd12345;
        #1;
        chk(host_rdata_re_o == 0 && host_rdata_im_o == 0, "R7 rdata zero while busy",
            int'(host_rdata_re_o), 0);
        start_i = 1'b1;
      end
      if (disturb && busy_cnt == 6) begin
        host_we_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    chk(busy_cnt == TOTAL, disturb ? "R8 length with start while busy" : "R3 busy length",
        busy_cnt, TOTAL);
    chk(done_o == 1'b1, "R3 done after run", done_o, 1);
    @(negedge clk_i);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R3 done held", done_o, 1);
    for (int k = 0; k < N; k++) begin
      real er = 0.0, ei = 0.0;
      int re, im, xre, xim;
      for (int n = 0; n < N; n++) begin
        real th = 6.283185307179586 * real'(n * k) / real'(N);
        er += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        ei += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
      xre = rndr(er / real'(N)); xim = rndr(ei / real'(N));
      host_read(bitrev(k), re, im);
      chk(iabs(re - xre) <= TOL && iabs(im - xim) <= TOL,
          disturb ? "R6 R4 bin" : "R4 bin", (re << 16) | (im & 16'hffff),
          (xre << 16) | (xim & 16'hffff));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 after release", busy_o, 0);

    // impulse
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 8000;
    load_frame(); run_and_check(1'b0);

    // single tone at bin 3
    for (int n = 0; n < N; n++) begin
      real th = 6.283185307179586 * 3.0 * real'(n) / real'(N);
      xr[n] = rndr(7000.0 * $cos(th)); xi[n] = rndr(7000.0 * $sin(th));
    end
    load_frame(); run_and_check(1'b0);

    // full-scale corners
    for (int n = 0; n < N; n++) begin
      xr[n] = (n % 2 == 0) ? 8000 : -8000; xi[n] = (n < N / 2) ? -8000 : 8000;
    end
    load_frame(); run_and_check(1'b0);

    // random frames, one with disturbance while busy
    for (int f = 0; f < 4; f++) begin
      for (int n = 0; n < N; n++) begin
        xr[n] = int'($urandom_range(16000)) - 8000;
        xi[n] = int'($urandom_range(16000)) - 8000;
      end
      load_frame(); run_and_check(f == 2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule